// File: doc/BRIEF.md
# Stored-Vector Self-Test Sequencer

This block is an on-chip harness for checking a device under test against a fixed list of patterns. Two vector memories sit beside it: one holds the stimulus, the other holds the expected result for each stimulus. Both memories share one address, which the sequencer drives. Both have a synchronous read port and return the word one clock after the address is presented. The sequencer passes each stimulus word on to the device with a valid strobe. It delays the matching expected word by the device's fixed result latency. It then compares the device result against that delayed word in the same cycle.

A run begins on a rising edge of `start`. While a run is in progress, `test_active` is high. The address steps once per clock through all `N_VEC` entries. A run ends in one of two ways. If every comparison has completed, `done` pulses for one cycle and `test_active` falls. If `start` is deasserted first, the run aborts at once: `test_active` falls, and any comparisons still in flight are discarded. `error` is sticky. It is cleared only when the next run begins.

The stimulus stream has a valid strobe but no ready input. The device must accept one word in every cycle in which `dut_valid` is high. It must also return its result exactly `RES_LAT` cycles later. No back-pressure is possible: the vector memories are read at a fixed rate, and stalling would break the alignment with the expected words.

Top module: `vst_selftest_seq`

## Requirements
- R1: After reset, `test_active`, `done`, `error` and `dut_valid` are 0 and `vec_addr` is 0.
- R2: A run begins only on a 0-to-1 transition of `start` while no run is in progress. At the clock edge that samples that transition, `test_active` goes to 1, `vec_addr` goes to 0 and `error` is cleared. Holding `start` high after a run ends does not begin a new run.
- R3: During a run, `vec_addr` steps by exactly one per clock, from 0 to `N_VEC-1`, presenting each address once. It then holds at `N_VEC-1` until the next run begins.
- R4: `dut_valid` is high for exactly `N_VEC` cycles per complete run. Each of these cycles is the cycle after its address was presented, and `dut_stim` carries the stimulus word of that address, in address order. `dut_valid` is never high while `test_active` is 0.
- R5: `dut_result` is sampled `RES_LAT` cycles after the `dut_valid` cycle of the same address. It is compared with the expected word of that address, and any mismatch sets `error`.
- R6: `error` stays set through the end of the run and afterwards, until the next run begins.
- R7: A complete run ends with `done` high for exactly one cycle. At that same edge `test_active` falls, which is `N_VEC + RES_LAT + 2` edges after the edge that began the run.
- R8: If `start` is 0 during a run, `test_active` falls at the next edge and `dut_valid` falls at that edge too. `done` does not pulse. Comparisons still in flight do not affect `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request; rising edge begins, low aborts |
| test_active | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a complete run |
| error | output | 1 | Sticky mismatch flag |
| vec_addr | output | AW | Shared read address for both vector memories |
| stim_rdata | input | VEC_W | Stimulus memory read data (one-cycle latency) |
| exp_rdata | input | RES_W | Expected memory read data (one-cycle latency) |
| dut_stim | output | VEC_W | Stimulus word to the device under test |
| dut_valid | output | 1 | Qualifies `dut_stim` |
| dut_result | input | RES_W | Device result, `RES_LAT` cycles after its stimulus |

## Verification
The assertions rely on two properties of the surroundings. First, both memories return their word exactly one clock after the address. Second, the device answers after a fixed `RES_LAT` with no stall. Under those conditions the valid strobe, the address stepping and the end of a run follow from the sequencer alone. The bench keeps within these assumptions by modelling each memory as a register read on the clock edge. It models the device as a two-stage registered function, and drives `start` only on the falling clock edge. Mismatches are produced by corrupting entries in the expected table, not by disturbing the device timing.

// File: rtl/vst_pkg.sv
package vst_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vst_ctrl.sv
module vst_ctrl
  import vst_pkg::*;
#(
  parameter int N_VEC = 16,
  parameter int AW    = addr_bits(N_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          drained,
  output logic          active,
  output logic          issue,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic          clr,
  output logic          flush
);
  localparam logic [AW-1:0] LAST = AW'(N_VEC - 1);

  seq_state_e st;
  logic       start_q;

  assign clr    = (st == SEQ_IDLE) && start && !start_q;
  assign flush  = (st == SEQ_RUN) && !start;
  assign active = (st == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      start_q <= 1'b0;
      issue   <= 1'b0;
      addr    <= '0;
      done    <= 1'b0;
    end else begin
      start_q <= start;
      done    <= 1'b0;
      if (clr) begin
        st    <= SEQ_RUN;
        issue <= 1'b1;
        addr  <= '0;
      end else if (flush) begin
        st    <= SEQ_IDLE;
        issue <= 1'b0;
      end else if (st == SEQ_RUN) begin
        if (issue) begin
          if (addr == LAST) issue <= 1'b0;
          else              addr  <= addr + 1'b1;
        end else if (drained) begin
          st   <= SEQ_IDLE;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vst_align.sv
module vst_align #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d,
  output logic         busy
);
  logic [LAT-1:0] v;
  logic [W-1:0]   d [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v[s] <= 1'b0;
        d[s] <= '0;
      end else begin
        v[s] <= flush ? 1'b0 : ((s == 0) ? in_v : v[(s == 0) ? 0 : s - 1]);
        d[s] <= (s == 0) ? in_d : d[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign out_v = v[LAT-1];
  assign out_d = d[LAT-1];
  assign busy  = |v;
endmodule

// File: rtl/vst_cmp.sv
module vst_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cmp_v,
  input  logic [W-1:0] res,
  input  logic [W-1:0] expd,
  output logic         err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       err <= 1'b0;
    else if (clr)                     err <= 1'b0;
    else if (cmp_v && (res != expd))  err <= 1'b1;
  end
endmodule

// File: rtl/vst_selftest_seq.sv
module vst_selftest_seq
  import vst_pkg::*;
#(
  parameter int N_VEC   = 16,
  parameter int VEC_W   = 8,
  parameter int RES_W   = 8,
  parameter int RES_LAT = 2,
  parameter int AW      = addr_bits(N_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             test_active,
  output logic             done,
  output logic             error,
  output logic [AW-1:0]    vec_addr,
  input  logic [VEC_W-1:0] stim_rdata,
  input  logic [RES_W-1:0] exp_rdata,
  output logic [VEC_W-1:0] dut_stim,
  output logic             dut_valid,
  input  logic [RES_W-1:0] dut_result
);
  logic             issue, clr, flush, rd_v, al_busy, cmp_v;
  logic [RES_W-1:0] exp_al;

  vst_ctrl #(.N_VEC(N_VEC), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .drained(!rd_v && !al_busy),
    .active(test_active), .issue(issue), .addr(vec_addr),
    .done(done), .clr(clr), .flush(flush)
  );

  // memory read takes one clock: valid follows the issued address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_v <= 1'b0;
    else        rd_v <= issue && !flush;
  end

  assign dut_stim  = stim_rdata;
  assign dut_valid = rd_v;

  vst_align #(.W(RES_W), .LAT(RES_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_v(rd_v), .in_d(exp_rdata),
    .out_v(cmp_v), .out_d(exp_al), .busy(al_busy)
  );

  vst_cmp #(.W(RES_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cmp_v(cmp_v), .res(dut_result), .expd(exp_al), .err(error)
  );
endmodule

// File: rtl/vst_seq_chk.sv
module vst_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          test_active,
  input logic          done,
  input logic          error,
  input logic          dut_valid,
  input logic [AW-1:0] vec_addr
);
  // R2
  run_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_active) |-> (vec_addr == '0) && !error);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active && $past(test_active) && (vec_addr != $past(vec_addr)))
      |-> (vec_addr == $past(vec_addr) + 1'b1));

  // R4
  valid_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dut_valid |-> test_active);

  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> test_active);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !test_active ##1 !done);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active && !start) |=> (!test_active && !dut_valid && !done));
endmodule

bind vst_selftest_seq vst_seq_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .test_active(test_active),
  .done(done), .error(error), .dut_valid(dut_valid), .vec_addr(vec_addr)
);

// File: tb/test_vst_selftest_seq.sv
module test_vst_selftest_seq;
  localparam int N   = 16;
  localparam int VW  = 8;
  localparam int RW  = 8;
  localparam int LAT = 2;
  localparam int AW  = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic test_active, done, error, dut_valid;
  logic [AW-1:0] vec_addr;
  logic [VW-1:0] stim_rdata, dut_stim;
  logic [RW-1:0] exp_rdata, dut_result, p1, p2;
  logic [VW-1:0] smem [N];
  logic [RW-1:0] emem [N];
  logic [VW-1:0] slog [64];
  int nlog = 0;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  vst_selftest_seq #(.N_VEC(N), .VEC_W(VW), .RES_W(RW), .RES_LAT(LAT)) i_vst_selftest_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .test_active(test_active),
    .done(done), .error(error), .vec_addr(vec_addr),
    .stim_rdata(stim_rdata), .exp_rdata(exp_rdata),
    .dut_stim(dut_stim), .dut_valid(dut_valid), .dut_result(dut_result)
  );

  function automatic logic [RW-1:0] fdut(input logic [VW-1:0] x);
    return {x[3:0], x[7:4]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    stim_rdata <= smem[vec_addr];
    exp_rdata  <= emem[vec_addr];
    p1 <= fdut(dut_stim);
    p2 <= p1;
    if (dut_valid && nlog < 64) begin
      slog[nlog] = dut_stim;
      nlog = nlog + 1;
    end
  end
  assign dut_result = p2;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int bad);
    for (int i = 0; i < N; i++) begin
      smem[i] = VW'(i * 37 + 11);
      emem[i] = fdut(smem[i]);
      if (i == bad) emem[i] = emem[i] ^ 8'h01;
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  // begins a run and runs it to completion, checking R2 R3 R7
  task automatic full_run(output int edges);
    nlog = 0;
    start = 1'b1;
    cyc();
    chk(test_active == 1'b1, "R2 active", int'(test_active), 1);
    chk(vec_addr == 0, "R2 addr", int'(vec_addr), 0);
    chk(error == 1'b0, "R2 error cleared", int'(error), 0);
    edges = 0;
    while (!done && edges < 200) begin
      cyc();
      edges++;
      if (edges < N) chk(int'(vec_addr) == edges, "R3 addr step", int'(vec_addr), edges);
    end
    chk(edges == N + LAT + 2, "R7 done timing", edges, N + LAT + 2);
    chk(test_active == 1'b0, "R7 active falls", int'(test_active), 0);
    chk(int'(vec_addr) == N - 1, "R3 addr holds", int'(vec_addr), N - 1);
    cyc();
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(!test_active && !done && !error && !dut_valid, "R1 outputs",
        int'({test_active, done, error, dut_valid}), 0);
    chk(vec_addr == 0, "R1 addr", int'(vec_addr), 0);
  endtask

  task automatic t_clean();
    int e;
    load(-1);
    full_run(e);
    chk(nlog == N, "R4 valid count", nlog, N);
    for (int i = 0; i < N && i < nlog; i++)
      chk(slog[i] == smem[i], "R4 stim order", int'(slog[i]), int'(smem[i]));
    chk(error == 1'b0, "R5 no mismatch", int'(error), 0);
    repeat (5) cyc();
    chk(test_active == 1'b0, "R2 held start no rerun", int'(test_active), 0);
    start = 1'b0;
    cyc();
  endtask

  task automatic t_mismatch(input int bad);
    int e;
    load(bad);
    full_run(e);
    chk(error == 1'b1, "R5 mismatch flagged", int'(error), 1);
    start = 1'b0;
    repeat (4) cyc();
    chk(error == 1'b1, "R6 sticky", int'(error), 1);
    load(-1);
    start = 1'b1;
    cyc();
    chk(error == 1'b0, "R6 cleared on start", int'(error), 0);
    start = 1'b0;
    cyc();
    repeat (3) cyc();
  endtask

  task automatic t_abort();
    bit saw_done = 1'b0;
    load(1);
    nlog = 0;
    start = 1'b1;
    repeat (4) cyc();
    start = 1'b0;
    cyc();
    chk(test_active == 1'b0, "R8 active falls", int'(test_active), 0);
    chk(dut_valid == 1'b0, "R8 valid falls", int'(dut_valid), 0);
    for (int i = 0; i < 8; i++) begin
      if (done) saw_done = 1'b1;
      cyc();
    end
    chk(!saw_done, "R8 no done", int'(saw_done), 0);
    chk(error == 1'b0, "R8 in-flight discarded", int'(error), 0);
    chk(nlog == 3, "R8 stim count", nlog, 3);
  endtask

  task automatic t_restart();
    int e;
    load(N - 1);
    full_run(e);
    chk(error == 1'b1, "R5 last entry mismatch", int'(error), 1);
    start = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    load(-1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_clean();
    t_mismatch(5);
    t_abort();
    t_restart();
    t_mismatch(0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule